// File: doc/BRIEF.md
# Serial Register Access Bridge

This block sits between a host that speaks a framed serial protocol and a converter's bank of ten-bit configuration registers. The host lowers an active-low load strobe, clocks sixteen bits on a serial clock and raises the strobe again. The bridge rebuilds the frame in the system clock domain and issues either a parallel write request or a read request. For a read, the host keeps clocking after the strobe has risen. The first trailing clock latches the addressed register, and the ten clocks that follow move its value out on the serial data output.

All three host pins are asynchronous to the system clock. Each passes through a two-flop synchroniser before any edge is detected, so the serial clock must stay well below the system clock rate. Write requests leave on a valid/ready interface. A request stays valid, with address and data held, until it is accepted. A frame that completes while an earlier write is still waiting is dropped. With ready tied high, every write is a pulse one system clock long. Read requests are plain one-cycle pulses. The read value comes back on a parallel input that the bridge samples at the capture clock.

Top module: `ser_reg_bridge`

## Requirements
- R1: During reset and after it, `sdo_o`, `wr_valid_o` and `rd_req_o` are 0.
- R2: A frame is read from `sdi_i` at serial clock rising edges while `load_n_i` is low. Slot 0 is the read flag (1 = read, 0 = write). Slots 1 to 4 carry the address, most significant bit first. Slot 5 is ignored. Slots 6 to 15 carry the data, most significant bit first.
- R3: A frame with any number of rising serial clocks other than 16 while load is low is discarded. It produces neither a write nor a read request.
- R4: A valid write frame raises `wr_valid_o` after load rises. With `wr_ready_i` high, exactly one transfer takes place per frame, carrying the frame's address and data.
- R5: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold. A write frame that completes during that time is dropped.
- R6: A valid read frame gives a one-cycle `rd_req_o` pulse, with the frame's address on `rd_addr_o`, and no write.
- R7: After a read frame, `rd_data_i` is sampled at the first serial clock rising edge after load rises. Later changes of `rd_data_i` do not affect the value sent.
- R8: `sdo_o` presents the captured bit 9 after the capture clock falls. It then moves to the next lower bit on each of the next nine falling edges, so the host reads bit 9 down to bit 0 at the rising edges of the ten shift clocks. It returns to 0 at the tenth shift clock's falling edge.
- R9: A falling load strobe abandons any readback in progress and forces `sdo_o` to 0. The new frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n_i | input | 1 | Host frame strobe, active low, asynchronous |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| sdi_i | input | 1 | Host serial data in |
| sdo_o | output | 1 | Serial readback data, changes after serial clock falls |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| rd_req_o | output | 1 | One-cycle read request pulse |
| rd_addr_o | output | ADDR_W | Read address, held until the next read |
| rd_data_i | input | DATA_W | Register value returned for the read |

## Verification
Directed frames with all-ones and all-zeros fields show that the field slots land on the right bits and that the ignored slot has no effect. Frames of 15 and 17 clocks separate a correct length check from one that counts too loosely. Readbacks that change the returned value just after the capture edge, or that cut a shift short with a new frame, separate the capture point and the abort path from the plain shift logic. A long seeded random mix of writes, reads and short frames then compares every transfer and every shifted bit against a register model kept in the bench.

// File: rtl/srab_pkg.sv
package srab_pkg;

  typedef enum logic [1:0] {
    RB_IDLE  = 2'd0,
    RB_ARM   = 2'd1,
    RB_HOLD  = 2'd2,
    RB_SHIFT = 2'd3
  } rb_state_e;

  function automatic int frame_slots(input int aw, input int dw);
    return aw + dw + 2;
  endfunction

endpackage

// File: rtl/srab_bit_sync.sv
module srab_bit_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/srab_edge_sync.sv
module srab_edge_sync #(
  parameter int           N       = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] sync_q;
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    srab_bit_sync #(.STAGES(2), .RST_VAL(RST_VAL[i])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (d_i[i]),
      .q_o  (sync_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sync_q;
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/srab_frame_rx.sv
module srab_frame_rx #(
  parameter int AW = 4,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start_i,
  input  logic          frame_end_i,
  input  logic          bit_strobe_i,
  input  logic          bit_val_i,
  output logic          done_o,
  output logic          is_rd_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int FLEN    = srab_pkg::frame_slots(AW, DW);
  localparam int KEEP_W  = AW + DW + 1;
  localparam int GAP_IDX = AW + 1;
  localparam int CW      = $clog2(FLEN + 2);

  logic              in_frame;
  logic [CW-1:0]     cnt;
  logic [KEEP_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (frame_start_i) begin
        in_frame <= 1'b1;
        cnt      <= '0;
        sh       <= '0;
      end else if (frame_end_i) begin
        in_frame <= 1'b0;
        done_o   <= in_frame && (cnt == CW'(FLEN));
      end else if (in_frame && bit_strobe_i) begin
        if (cnt != CW'(FLEN + 1)) cnt <= cnt + 1'b1;
        if (cnt != CW'(GAP_IDX) && cnt < CW'(FLEN))
          sh <= {sh[KEEP_W-2:0], bit_val_i};
      end
    end
  end

  assign is_rd_o = sh[KEEP_W-1];
  assign addr_o  = sh[DW +: AW];
  assign data_o  = sh[DW-1:0];
endmodule

// File: rtl/srab_rdback_tx.sv
module srab_rdback_tx #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          sck_rise_i,
  input  logic          sck_fall_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sdo_o
);
  import srab_pkg::*;
  localparam int CW = $clog2(DW + 1);

  rb_state_e     st;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RB_IDLE;
      sh    <= '0;
      cnt   <= '0;
      sdo_o <= 1'b0;
    end else if (abort_i) begin
      st    <= RB_IDLE;
      sdo_o <= 1'b0;
    end else if (start_i) begin
      st    <= RB_ARM;
      sdo_o <= 1'b0;
    end else begin
      unique case (st)
        RB_ARM: if (sck_rise_i) begin
          sh <= rd_data_i;
          st <= RB_HOLD;
        end
        RB_HOLD: if (sck_fall_i) begin
          sdo_o <= sh[DW-1];
          sh    <= {sh[DW-2:0], 1'b0};
          cnt   <= '0;
          st    <= RB_SHIFT;
        end
        RB_SHIFT: if (sck_fall_i) begin
          if (cnt == CW'(DW - 1)) begin
            sdo_o <= 1'b0;
            st    <= RB_IDLE;
          end else begin
            sdo_o <= sh[DW-1];
            sh    <= {sh[DW-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ser_reg_bridge.sv
module ser_reg_bridge #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int LD = 1;
  localparam int SK = 0;

  logic [1:0]        rise_v, fall_v;
  logic              ld_rise, ld_fall, sck_rise, sck_fall;
  logic              sdi_s;
  logic              rx_done, rx_is_rd;
  logic [ADDR_W-1:0] rx_addr;
  logic [DATA_W-1:0] rx_data;
  logic              wr_fire, wr_take, rd_take;

  srab_edge_sync #(.N(2), .RST_VAL(2'b10)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({load_n_i, sclk_i}),
    .rise_o(rise_v),
    .fall_o(fall_v)
  );

  srab_bit_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sdi (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (sdi_i),
    .q_o  (sdi_s)
  );

  assign ld_rise  = rise_v[LD];
  assign ld_fall  = fall_v[LD];
  assign sck_rise = rise_v[SK];
  assign sck_fall = fall_v[SK];

  srab_frame_rx #(.AW(ADDR_W), .DW(DATA_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(ld_fall),
    .frame_end_i  (ld_rise),
    .bit_strobe_i (sck_rise),
    .bit_val_i    (sdi_s),
    .done_o       (rx_done),
    .is_rd_o      (rx_is_rd),
    .addr_o       (rx_addr),
    .data_o       (rx_data)
  );

  assign wr_fire = wr_valid_o && wr_ready_i;
  assign wr_take = rx_done && !rx_is_rd && (!wr_valid_o || wr_fire);
  assign rd_take = rx_done && rx_is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      rd_req_o   <= 1'b0;
      rd_addr_o  <= '0;
    end else begin
      if (wr_take) begin
        wr_valid_o <= 1'b1;
        wr_addr_o  <= rx_addr;
        wr_data_o  <= rx_data;
      end else if (wr_fire) begin
        wr_valid_o <= 1'b0;
      end
      rd_req_o <= rd_take;
      if (rd_take) rd_addr_o <= rx_addr;
    end
  end

  srab_rdback_tx #(.DW(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (rd_take),
    .abort_i   (ld_fall),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .rd_data_i (rd_data_i),
    .sdo_o     (sdo_o)
  );
endmodule

// File: rtl/srab_checker.sv
module srab_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              rd_req_o,
  input logic              sdo_o,
  input logic              rx_done,
  input logic              ld_fall
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid_o && !rd_req_o && !sdo_o));

  a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  a_r3_write_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid_o) |-> $past(rx_done));

  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  a_r6_rd_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> $past(rx_done));

  a_r6_no_mixed: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && $rose(wr_valid_o)));

  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> !sdo_o);
endmodule

bind ser_reg_bridge srab_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .rd_req_o  (rd_req_o),
  .sdo_o     (sdo_o),
  .rx_done   (rx_done),
  .ld_fall   (ld_fall)
);

// File: tb/ser_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module ser_reg_bridge_tb_top;
  localparam int AW = 4;
  localparam int DW = 10;
  localparam int HP = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_n = 1'b1;
  logic          sclk = 1'b0;
  logic          sdi = 1'b0;
  logic          sdo;
  logic          wr_valid;
  logic          wr_ready = 1'b1;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  logic [DW-1:0] dev_mem [16];
  logic [DW-1:0] exp_mem [16];
  logic          ovr = 1'b0;
  logic [DW-1:0] ovr_val = '0;

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [AW-1:0] last_wa, last_ra;
  logic [DW-1:0] last_wd;

  always #5 clk = ~clk;

  ser_reg_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n_i(load_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_req_o(rd_req),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  assign rd_data = ovr ? ovr_val : dev_mem[rd_addr];

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        wr_cnt  <= wr_cnt + 1;
        last_wa <= wr_addr;
        last_wd <= wr_data;
        dev_mem[wr_addr] <= wr_data;
      end
      if (rd_req) begin
        rd_cnt  <= rd_cnt + 1;
        last_ra <= rd_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_word(input bit rd, input logic [AW-1:0] a,
                                          input logic [DW-1:0] d, input bit gap);
    return {rd, a, gap, d};
  endfunction

  task automatic send_frame(input bit rd, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int nclk, input bit gap);
    logic [15:0] w;
    w = mk_word(rd, a, d, gap);
    load_n = 1'b0;
    #HP;
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      #HP; sclk = 1'b1;
      #HP; sclk = 1'b0;
    end
    sdi = 1'b0;
    #HP; load_n = 1'b1;
    #(2*HP);
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; #HP; sclk = 1'b0; #HP;
  endtask

  // capture clock then ten shift clocks; compare each bit before its rising edge
  task automatic readback(input logic [DW-1:0] exp, input string req);
    logic [DW-1:0] got;
    got = '0;
    pulse_sclk();
    for (int k = 0; k < DW; k++) begin
      got[DW-1-k] = sdo;
      pulse_sclk();
    end
    chk(got == exp, req, got, exp);
    chk(sdo == 1'b0, "R8 idle after shift", sdo, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int c0;
    c0 = wr_cnt;
    send_frame(1'b0, a, d, 16, 1'b1);
    chk(wr_cnt == c0 + 1, "R4 one transfer", wr_cnt - c0, 1);
    chk(last_wa == a, "R2 addr field", last_wa, a);
    chk(last_wd == d, "R2 data field", last_wd, d);
    exp_mem[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int c0, w0;
    c0 = rd_cnt; w0 = wr_cnt;
    send_frame(1'b1, a, $urandom_range(1023), 16, $urandom_range(1));
    chk(rd_cnt == c0 + 1, "R6 read request", rd_cnt - c0, 1);
    chk(last_ra == a, "R6 read addr", last_ra, a);
    chk(wr_cnt == w0, "R6 no write on read", wr_cnt - w0, 0);
    readback(exp_mem[a], "R8 readback bits");
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vcyc, w0, r0, seed;
    seed = $urandom(32'h5eed_0042);
    for (int i = 0; i < 16; i++) begin dev_mem[i] = '0; exp_mem[i] = '0; end
    #40;
    chk(!sdo && !wr_valid && !rd_req, "R1 reset outputs", {sdo, wr_valid, rd_req}, 0);
    #60 rst_n = 1'b1;
    #100;
    chk(!sdo && !wr_valid && !rd_req, "R1 after reset", {sdo, wr_valid, rd_req}, 0);

    // R2/R4 directed extremes, gap slot driven both ways
    do_write(4'hF, 10'h3FF);
    do_write(4'h0, 10'h000);
    do_write(4'hA, 10'h155);
    send_frame(1'b0, 4'h5, 10'h2AA, 16, 1'b0);
    chk(last_wa == 4'h5 && last_wd == 10'h2AA, "R2 gap slot ignored", last_wd, 10'h2AA);
    exp_mem[5] = 10'h2AA;

    // R4 pulse width with ready high
    vcyc = 0;
    fork
      send_frame(1'b0, 4'h3, 10'h0F0, 16, 1'b0);
      repeat (400) @(negedge clk) if (wr_valid) vcyc++;
    join
    chk(vcyc == 1, "R4 single-cycle valid", vcyc, 1);
    exp_mem[3] = 10'h0F0;

    // R3 wrong lengths
    w0 = wr_cnt; r0 = rd_cnt;
    send_frame(1'b0, 4'h1, 10'h111, 15, 1'b0);
    send_frame(1'b0, 4'h1, 10'h111, 17, 1'b0);
    send_frame(1'b1, 4'h1, 10'h111, 15, 1'b0);
    send_frame(1'b1, 4'h1, 10'h111, 17, 1'b0);
    chk(wr_cnt == w0, "R3 short/long write dropped", wr_cnt - w0, 0);
    chk(rd_cnt == r0, "R3 short/long read dropped", rd_cnt - r0, 0);

    // R6/R8 directed reads
    do_read(4'hF);
    do_read(4'hA);
    do_read(4'h0);

    // R7 capture point: value changes right after capture edge
    send_frame(1'b1, 4'h2, 10'h0, 16, 1'b0);
    ovr = 1'b1; ovr_val = 10'h2C3;
    sclk = 1'b1; #(HP/2); ovr_val = 10'h13C; #(HP/2); sclk = 1'b0; #HP;
    begin
      logic [DW-1:0] got;
      got = '0;
      for (int k = 0; k < DW; k++) begin got[DW-1-k] = sdo; pulse_sclk(); end
      chk(got == 10'h2C3, "R7 capture at first trailing clock", got, 10'h2C3);
    end
    ovr = 1'b0;

    // R9 abort mid-shift
    do_write(4'h7, 10'h3FF);
    send_frame(1'b1, 4'h7, 10'h0, 16, 1'b0);
    pulse_sclk();
    pulse_sclk(); pulse_sclk(); pulse_sclk();
    chk(sdo == 1'b1, "R8 mid-shift bit", sdo, 1);
    w0 = wr_cnt;
    send_frame(1'b0, 4'h8, 10'h1A5, 16, 1'b0);
    chk(sdo == 1'b0, "R9 sdo low after abort", sdo, 0);
    chk(wr_cnt == w0 + 1 && last_wd == 10'h1A5, "R9 new frame received", last_wd, 10'h1A5);
    exp_mem[8] = 10'h1A5;

    // R5 back-pressure
    wr_ready = 1'b0;
    w0 = wr_cnt;
    send_frame(1'b0, 4'h9, 10'h321, 16, 1'b1);
    repeat (20) @(negedge clk);
    chk(wr_valid == 1'b1, "R5 valid held", wr_valid, 1);
    chk(wr_addr == 4'h9 && wr_data == 10'h321, "R5 payload held", wr_data, 10'h321);
    send_frame(1'b0, 4'hB, 10'h0AB, 16, 1'b0);
    chk(wr_addr == 4'h9 && wr_data == 10'h321, "R5 second frame dropped", wr_data, 10'h321);
    @(negedge clk) wr_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk(wr_cnt == w0 + 1 && !wr_valid, "R5 one transfer after stall", wr_cnt - w0, 1);
    exp_mem[9] = 10'h321;

    // random mix
    for (int n = 0; n < 45; n++) begin
      int kind;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      kind = $urandom_range(9);
      a = AW'($urandom_range(15));
      d = DW'($urandom_range(1023));
      if (kind < 4) do_write(a, d);
      else if (kind < 8) do_read(a);
      else begin
        w0 = wr_cnt; r0 = rd_cnt;
        send_frame(kind[0], a, d, (kind == 8) ? $urandom_range(1, 15) : $urandom_range(17, 20), 1'b0);
        chk(wr_cnt == w0 && rd_cnt == r0, "R3 random bad length", wr_cnt + rd_cnt - w0 - r0, 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule